// File: doc/BRIEF.md
# Sectored Wait-State External SRAM Bus Controller

This controller links a CPU-side byte request port to an external parallel SRAM. It uses an 8-bit bus that carries the low address byte first and then the data byte, a separate high address byte, an address latch strobe, and active-low read and write strobes. The address range splits into a lower and an upper sector at a programmable boundary. Each sector has its own two-bit wait code, which sets how long the strobe is held.

A request is accepted while `ready` is high and the interface is enabled. `ready` stays low for the whole bus sequence. When `ready` returns high, read data is available on `rdata`. The CPU side also supplies a hint (`next_ram`) that says whether the following access will touch RAM. This hint controls the optional latch pulse at the end of the longest sequence. When the interface is disabled, every pin output and output-enable comes straight from the general-purpose port inputs.

Top module: `sram_sector_bus`

## Requirements
- R1: After reset, all control fields are zero and the interface is disabled. Every `pin_*` output and output-enable equals the matching `port_*` input, `ready` is high and `rdata` is zero.
- R2: While enabled and idle, `pin_ctl_oe` is 3'b111 and `pin_ahi_oe` is all ones. The control pins `pin_ctl_out` = {latch, wr_n, rd_n} (bit 2 = latch, bit 1 = write strobe, bit 0 = read strobe) read 3'b011.
- R3: In the first cycle after acceptance, the latch pin is high and the muxed bus drives `addr[7:0]` with all enables set. The high pins carry `addr[15:8]`, and they hold that value for the rest of the access. The strobe starts exactly two cycles after the address latch cycle.
- R4: On a write, the muxed bus carries `wdata` from the cycle after the latch cycle. It stays driven and unchanged for every cycle that wr_n is low, and it is released in the cycle after wr_n rises.
- R5: On a read, the muxed bus enables are off while rd_n is low. The value on `pin_ad_in` in the last strobe cycle is captured at that cycle's closing edge. That value appears on `rdata` when `ready` returns high.
- R6: The wait code selects the strobe length: 00 gives 1 cycle, 01 gives 2, 10 gives 3 and 11 gives 3. The number of cycles `ready` stays low is 4, 5, 6 and 7 respectively.
- R7: With wait code 11, one extra hold cycle follows strobe release. In that cycle the latch pin pulses (with the muxed bus undriven) only if `next_ram` was high when the request was accepted. No other code produces a closing pulse.
- R8: If the sector limit is 0, the lower-sector wait code applies to every address. If the limit L is 1 to 7, addresses with `addr[15:13] < L` use the lower code and all other addresses use the upper code.
- R9: Writing `ctla_wr` loads `ctla_d` as {enable (bit 1), upper-sector wait bit 1 (bit 0)}. Writing `ctlb_wr` loads `ctlb_d` as {limit (bits 5:3), lower-sector wait code (bits 2:1), upper-sector wait bit 0 (bit 0)}.
- R10: While disabled, `req` is ignored. `ready` stays high, no strobe is produced, and the pins keep following the port inputs.
- R11: The read and write strobes are never low together, and the latch pin is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctla_wr | input | 1 | Load strobe for control group A |
| ctla_d | input | 2 | {enable, upper wait bit 1} |
| ctlb_wr | input | 1 | Load strobe for control group B |
| ctlb_d | input | 6 | {limit[2:0], lower wait[1:0], upper wait bit 0} |
| req | input | 1 | Access request |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 16 | Access address |
| wdata | input | 8 | Write data |
| next_ram | input | 1 | Following access targets RAM |
| ready | output | 1 | Idle and able to accept |
| rdata | output | 8 | Last read data |
| port_ad_out | input | 8 | Port value for the muxed pins |
| port_ad_oe | input | 8 | Port enables for the muxed pins |
| port_ahi_out | input | 8 | Port value for the high pins |
| port_ahi_oe | input | 8 | Port enables for the high pins |
| port_ctl_out | input | 3 | Port value for the control pins |
| port_ctl_oe | input | 3 | Port enables for the control pins |
| pin_ad_out | output | 8 | Muxed address/data pin value |
| pin_ad_oe | output | 8 | Muxed pin enables |
| pin_ad_in | input | 8 | Muxed pin input |
| pin_ahi_out | output | 8 | High address pin value |
| pin_ahi_oe | output | 8 | High address pin enables |
| pin_ctl_out | output | 3 | {latch, wr_n, rd_n} |
| pin_ctl_oe | output | 3 | Control pin enables |

## Verification
A wrong wait code or a misread sector boundary shows up within a single access. The strobe count and the length of the `ready` low window both differ from the values in R6. A corrupted latched address or data byte is visible on the pins in the address cycle or in the first write strobe cycle. A lost or inverted `next_ram` bit surfaces in the last cycle before `ready` rises, when the closing latch pulse appears or fails to appear. A capture taken on the wrong edge gives a wrong `rdata` as soon as `ready` returns.

// File: rtl/sram_sector_bus.sv
module sram_sector_bus #(
  parameter int AW     = 16,
  parameter int DW     = 8,
  parameter int SECT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctla_wr,
  input  logic [1:0]        ctla_d,
  input  logic              ctlb_wr,
  input  logic [SECT_W+2:0] ctlb_d,
  input  logic              req,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  input  logic              next_ram,
  output logic              ready,
  output logic [DW-1:0]     rdata,
  input  logic [DW-1:0]     port_ad_out,
  input  logic [DW-1:0]     port_ad_oe,
  input  logic [AW-DW-1:0]  port_ahi_out,
  input  logic [AW-DW-1:0]  port_ahi_oe,
  input  logic [2:0]        port_ctl_out,
  input  logic [2:0]        port_ctl_oe,
  output logic [DW-1:0]     pin_ad_out,
  output logic [DW-1:0]     pin_ad_oe,
  input  logic [DW-1:0]     pin_ad_in,
  output logic [AW-DW-1:0]  pin_ahi_out,
  output logic [AW-DW-1:0]  pin_ahi_oe,
  output logic [2:0]        pin_ctl_out,
  output logic [2:0]        pin_ctl_oe
);
  localparam int HW = AW - DW;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_SETUP, S_STRB, S_REL, S_HOLD} state_t;

  state_t             state;
  logic               en_q, hw1_q, hw0_q;
  logic [SECT_W-1:0]  lim_q;
  logic [1:0]         lo_wait_q;
  logic [AW-1:0]      a_q;
  logic [DW-1:0]      d_q, rd_q;
  logic               we_q, nr_q;
  logic [1:0]         wc_q, cnt_q;

  logic               in_upper, accept;
  logic [1:0]         sel_wait, extra;
  logic               ale, wr_n, rd_n, bus_oe;
  logic [DW-1:0]      bus_ad;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_q      <= 1'b0;
      hw1_q     <= 1'b0;
      hw0_q     <= 1'b0;
      lim_q     <= '0;
      lo_wait_q <= 2'b00;
    end else begin
      if (ctla_wr) {en_q, hw1_q} <= ctla_d;
      if (ctlb_wr) {lim_q, lo_wait_q, hw0_q} <= ctlb_d;
    end

  assign in_upper = (lim_q != '0) && (addr[AW-1 -: SECT_W] >= lim_q);
  assign sel_wait = in_upper ? {hw1_q, hw0_q} : lo_wait_q;
  assign extra    = (sel_wait == 2'b00) ? 2'd0 : (sel_wait == 2'b01) ? 2'd1 : 2'd2;
  assign accept   = en_q && req && (state == S_IDLE);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= S_IDLE;
      a_q   <= '0;
      d_q   <= '0;
      rd_q  <= '0;
      we_q  <= 1'b0;
      nr_q  <= 1'b0;
      wc_q  <= 2'b00;
      cnt_q <= 2'd0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          state <= S_ADDR;
          a_q   <= addr;
          d_q   <= wdata;
          we_q  <= we;
          nr_q  <= next_ram;
          wc_q  <= sel_wait;
          cnt_q <= extra;
        end
        S_ADDR:  state <= S_SETUP;
        S_SETUP: state <= S_STRB;
        S_STRB: begin
          if (cnt_q == 2'd0) begin
            state <= S_REL;
            if (!we_q) rd_q <= pin_ad_in;
          end else begin
            cnt_q <= cnt_q - 2'd1;
          end
        end
        S_REL:   state <= (wc_q == 2'b11) ? S_HOLD : S_IDLE;
        S_HOLD:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end

  assign ready  = (state == S_IDLE);
  assign rdata  = rd_q;

  assign ale    = (state == S_ADDR) || (state == S_HOLD && nr_q);
  assign wr_n   = !(state == S_STRB && we_q);
  assign rd_n   = !(state == S_STRB && !we_q);
  assign bus_oe = (state == S_ADDR) || (we_q && (state == S_SETUP || state == S_STRB));
  assign bus_ad = (state == S_ADDR) ? a_q[DW-1:0] : d_q;

  assign pin_ad_out  = en_q ? bus_ad          : port_ad_out;
  assign pin_ad_oe   = en_q ? {DW{bus_oe}}    : port_ad_oe;
  assign pin_ahi_out = en_q ? a_q[AW-1:DW]    : port_ahi_out;
  assign pin_ahi_oe  = en_q ? {HW{1'b1}}      : port_ahi_oe;
  assign pin_ctl_out = en_q ? {ale, wr_n, rd_n} : port_ctl_out;
  assign pin_ctl_oe  = en_q ? 3'b111          : port_ctl_oe;
endmodule

// File: rtl/sram_sector_bus_chk.sv
module sram_sector_bus_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          ready,
  input logic [2:0]    ctl,
  input logic          ad_oe,
  input logic [DW-1:0] ad_out
);
  logic strobe;
  assign strobe = !ctl[1] || !ctl[0];

  assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (ctl[1] || ctl[0]));

  assert_latch_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ctl[2]) |=> (!en || !ctl[2]));

  assert_strobe_after_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en, 2) && $rose(strobe)) |-> $past(ctl[2], 2));

  assert_read_bus_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !ctl[0]) |-> !ad_oe);

  assert_write_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && !ctl[1] && $past(!ctl[1])) |-> ($stable(ad_out) && ad_oe));

  assert_idle_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && ready) |=> ready);
endmodule

bind sram_sector_bus sram_sector_bus_chk #(.DW(DW)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .en    (en_q),
  .ready (ready),
  .ctl   (pin_ctl_out),
  .ad_oe (pin_ad_oe[0]),
  .ad_out(pin_ad_out)
);

// File: tb/test_sram_sector_bus.sv
module test_sram_sector_bus;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic ctla_wr = 0, ctlb_wr = 0;
  logic [1:0] ctla_d = 0;
  logic [5:0] ctlb_d = 0;
  logic req = 0, we = 0, next_ram = 0;
  logic [15:0] addr = 0;
  logic [7:0] wdata = 0;
  logic ready;
  logic [7:0] rdata;
  logic [7:0] port_ad_out = 8'hC3, port_ad_oe = 8'h5A, port_ahi_out = 8'h96, port_ahi_oe = 8'h0F;
  logic [2:0] port_ctl_out = 3'b101, port_ctl_oe = 3'b010;
  logic [7:0] pin_ad_out, pin_ad_oe, pin_ad_in, pin_ahi_out, pin_ahi_oe;
  logic [2:0] pin_ctl_out, pin_ctl_oe;

  sram_sector_bus i_sram_sector_bus (.*);

  typedef struct {
    logic        wr;
    logic [15:0] a;
    logic [7:0]  d;
    int          busy;
    int          strb;
    logic        hold_ale;
  } exp_t;

  exp_t q[$];
  int n_tests = 0, n_fail = 0;
  bit done = 0;
  logic [2:0] b_lim = 0;
  logic [1:0] b_lo = 0, b_hi = 0;
  logic [15:0] mon_addr = 0;

  function automatic logic [7:0] pat(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  assign pin_ad_in = (pin_ctl_out[0] == 1'b0) ? pat(mon_addr) : 8'h00;

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // monitor
  int busy = 0, strb = 0;
  logic hold_ale = 0, prev_ready = 1, w_seen = 0, w_ok = 1;
  logic [7:0] w_first = 0, w_last = 0;
  always @(negedge clk) if (rst_n) begin
    if (!ready) begin
      busy++;
      if (pin_ctl_out[2] && pin_ad_oe[0]) mon_addr = {pin_ahi_out, pin_ad_out};
      if (pin_ctl_out[2] && !pin_ad_oe[0]) hold_ale = 1;
      if (pin_ahi_out != mon_addr[15:8]) w_ok = 0;
      if (!pin_ctl_out[1]) begin
        strb++;
        if (!w_seen) w_first = pin_ad_out;
        w_seen = 1;
        w_last = pin_ad_out;
        if (!pin_ad_oe[0]) w_ok = 0;
      end
      if (!pin_ctl_out[0]) strb++;
    end else if (!prev_ready) begin
      exp_t e;
      if (q.size() == 0) check("R10 unexpected access", 1, 0);
      else begin
        e = q.pop_front();
        check("R3 address", mon_addr, e.a);
        check("R6 busy cycles", busy, e.busy);
        check("R6 strobe cycles", strb, e.strb);
        check("R7 closing latch", hold_ale, e.hold_ale);
        check("R3 high byte held", w_ok, 1);
        if (e.wr) begin
          check("R4 write data first", w_first, e.d);
          check("R4 write data last", w_last, e.d);
        end else begin
          check("R5 read data", rdata, pat(e.a));
        end
      end
      busy = 0; strb = 0; hold_ale = 0; w_seen = 0; w_ok = 1;
    end
    prev_ready = ready;
  end

  task automatic wr_a(input logic [1:0] v);
    @(posedge clk); #2 ctla_wr = 1; ctla_d = v;
    @(posedge clk); #2 ctla_wr = 0;
  endtask

  task automatic wr_b(input logic [2:0] lim, input logic [1:0] lo, input logic hw0);
    @(posedge clk); #2 ctlb_wr = 1; ctlb_d = {lim, lo, hw0};
    @(posedge clk); #2 ctlb_wr = 0;
  endtask

  task automatic access(input logic w, input logic [15:0] a, input logic [7:0] d, input logic nr);
    exp_t e;
    logic [1:0] c;
    c = (b_lim == 0 || a[15:13] < b_lim) ? b_lo : b_hi;
    e.wr = w; e.a = a; e.d = d;
    e.strb = (c == 2'b00) ? 1 : (c == 2'b01) ? 2 : 3;
    e.busy = 3 + e.strb + ((c == 2'b11) ? 1 : 0);
    e.hold_ale = (c == 2'b11) && nr;
    q.push_back(e);
    @(posedge clk); #2 req = 1; we = w; addr = a; wdata = d; next_ram = nr;
    @(posedge clk); #2 req = 0;
    @(negedge clk);
    while (!ready) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    n_tests++; n_fail++;
    $display("FAIL R6 watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    check("R1 ready", ready, 1);
    check("R1 rdata", rdata, 0);
    check("R1 ad out", pin_ad_out, port_ad_out);
    check("R1 ad oe", pin_ad_oe, port_ad_oe);
    check("R1 ahi", {pin_ahi_out, pin_ahi_oe}, {port_ahi_out, port_ahi_oe});
    check("R1 ctl", {pin_ctl_out, pin_ctl_oe}, {port_ctl_out, port_ctl_oe});
    rst_n = 1;

    // R10 disabled: request ignored
    @(posedge clk); #2 req = 1; we = 0; addr = 16'h1234;
    repeat (3) begin
      @(negedge clk);
      check("R10 ready stays", ready, 1);
      check("R10 ctl follows port", pin_ctl_out, port_ctl_out);
    end
    @(posedge clk); #2 req = 0; port_ad_out = 8'h3C;
    @(negedge clk);
    check("R10 ad follows port", pin_ad_out, 8'h3C);

    // R9 group A enable, R2 idle levels
    wr_a(2'b10);
    @(negedge clk);
    check("R2 ctl oe", pin_ctl_oe, 3'b111);
    check("R2 ahi oe", pin_ahi_oe, 8'hFF);
    check("R2 idle ctl", pin_ctl_out, 3'b011);

    // R8 limit 0: upper code ignored
    wr_a(2'b11); b_hi[1] = 1;
    wr_b(3'd0, 2'b00, 1'b1); b_lim = 0; b_lo = 2'b00; b_hi[0] = 1;
    access(1, 16'hF0A5, 8'h3E, 1);
    access(0, 16'hF0A5, 8'h00, 1);
    access(0, 16'h0011, 8'h00, 0);

    // R6 each lower code
    wr_b(3'd0, 2'b01, 1'b1); b_lo = 2'b01;
    access(1, 16'h2345, 8'hA1, 0);
    access(0, 16'h2345, 8'h00, 0);
    wr_b(3'd0, 2'b10, 1'b1); b_lo = 2'b10;
    access(1, 16'h8001, 8'h7F, 0);
    access(0, 16'h8001, 8'h00, 0);
    wr_b(3'd0, 2'b11, 1'b1); b_lo = 2'b11;
    access(1, 16'h4242, 8'hC9, 1);
    access(0, 16'h4242, 8'h00, 0);
    access(0, 16'hBEEF, 8'h00, 1);

    // R8 boundary at limit 3, R7 hint
    wr_b(3'd3, 2'b01, 1'b1); b_lim = 3; b_lo = 2'b01;
    access(0, 16'h5FFF, 8'h00, 1);
    access(1, 16'h6000, 8'h55, 1);
    access(0, 16'h6000, 8'h00, 0);

    // R9 upper bit 1 in group A: clear it -> upper code 01
    wr_a(2'b10); b_hi = 2'b01;
    access(1, 16'h6001, 8'h18, 1);
    wr_b(3'd7, 2'b00, 1'b0); b_lim = 7; b_lo = 2'b00; b_hi = 2'b00;
    wr_a(2'b11); b_hi = 2'b10;
    access(0, 16'hDFFF, 8'h00, 0);
    access(0, 16'hE000, 8'h00, 1);
    access(1, 16'hFFFF, 8'h81, 1);

    repeat (3) @(negedge clk);
    check("R7 queue drained", q.size(), 0);
    check("R2 back to idle", pin_ctl_out, 3'b011);
    finish_run();
  end
endmodule